// File: doc/BRIEF.md
# Descriptor Address/Index Translator

This block maps descriptor memory addresses to global link-list indices and back. Descriptor memory is described by a small table of regions. Each region holds equally sized descriptors and records four things: a base address, a descriptor size, a descriptor count, and the first link-list index that the region occupies.

A queue engine uses the translator in two ways. When it pushes a descriptor, it presents the descriptor's address and gets back the matching index. When it pops an index, it presents that index and gets back the descriptor's address.

The region table is loaded through a single write port. The port checks every entry for alignment, size, count and index span. An entry that breaks any rule is dropped and an error is flagged instead. Both lookup paths have a fixed latency of two cycles and accept a new request on every cycle. Lookups read the table as it stands in the second stage.

Top module: `desc_xlate`

## Requirements
- R1: A configuration write whose base address has any of bits [3:0] set is rejected. The region table keeps its old contents, and `cfg_err_o` is high in the cycle after the write.
- R2: A configuration write is rejected in the same way when the descriptor size in bytes is not a power of two, or is below 32.
- R3: A configuration write is rejected when the descriptor count is not a power of two, or is below 32.
- R4: A configuration write is rejected when start index plus count exceeds 0x7FFF, or when the selected region number is not below the region count. A write that obeys R1 to R4 replaces the selected entry and leaves `cfg_err_o` low.
- R5: A push lookup returns start + (addr − base) / size for the region that holds the address, with `push_err_o` low.
- R6: A push address that no valid region holds on a descriptor boundary returns index 0x7FFF with `push_err_o` high. This covers an address below a base, an address at or beyond base + count × size, and an address between descriptors.
- R7: A pop lookup returns base + (idx − start) × size for the region whose index span holds the index. An index outside every span returns address 0 with `pop_err_o` high.
- R8: When more than one valid region accepts a request, the lowest numbered region supplies the result. A push address is accepted only when it lies on that region's descriptor boundary, so an address that one region rejects as off-boundary can still be accepted by a later region.
- R9: Each accepted request produces exactly one result valid two clock edges after the edge that samples it. Requests may arrive on back-to-back cycles.
- R10: After reset no region is valid, so every lookup reports an error, and `cfg_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Region table write strobe |
| cfg_sel_i | input | SEL_W | Region number to write |
| cfg_base_i | input | 32 | Region base address |
| cfg_start_i | input | 15 | First link-list index of the region |
| cfg_size_i | input | 16 | Descriptor size in bytes |
| cfg_count_i | input | 16 | Number of descriptors |
| cfg_err_o | output | 1 | Previous write was rejected |
| push_valid_i | input | 1 | Address-to-index request |
| push_addr_i | input | 32 | Descriptor address |
| push_valid_o | output | 1 | Index result valid |
| push_idx_o | output | 15 | Index, 0x7FFF on error |
| push_err_o | output | 1 | Address not translatable |
| pop_valid_i | input | 1 | Index-to-address request |
| pop_idx_i | input | 15 | Link-list index |
| pop_valid_o | output | 1 | Address result valid |
| pop_addr_o | output | 32 | Descriptor address, 0 on error |
| pop_err_o | output | 1 | Index not in any region |

## Verification
The bench builds overlapping regions so that priority matters. An address lies inside a large-descriptor region but off its boundary and on a smaller region's boundary. A design that stops at the first region whose range holds the address would flag that address in error. A design that searches from the top of the table would return a later region's index.

The bench also probes the last descriptor of each region and the one just past it. It probes a region that ends exactly at index 0x7FFE, where an off-by-one span check would accept or reject the wrong entry.

Each configuration rule is broken in turn, one of them while overwriting a live region. Lookups then confirm that nothing changed. A design that wrote before checking would corrupt later results.

Requests on back-to-back cycles expose a lost or duplicated result, or a latency other than two.

// File: rtl/desc_xlate_pkg.sv
package desc_xlate_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned IDX_W    = 15;
  localparam int unsigned SIZE_W   = 16;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned LOG_W    = 5;
  localparam int unsigned MIN_LOG  = 5;
  localparam logic [IDX_W-1:0] IDX_NULL = '1;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  start;
    logic [LOG_W-1:0]  size_log;
    logic [LOG_W-1:0]  cnt_log;
  } region_t;

  function automatic logic [LOG_W-1:0] onehot_log2(input logic [15:0] v);
    logic [LOG_W-1:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) if (v[i]) r = LOG_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/desc_region_table.sv
module desc_region_table
  import desc_xlate_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 20,
  localparam int unsigned SEL_W = $clog2(NUM_REGIONS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic [SEL_W-1:0]              cfg_sel_i,
  input  logic [ADDR_W-1:0]             cfg_base_i,
  input  logic [IDX_W-1:0]              cfg_start_i,
  input  logic [SIZE_W-1:0]             cfg_size_i,
  input  logic [CNT_W-1:0]              cfg_count_i,
  output logic                          cfg_err_o,
  output region_t [NUM_REGIONS-1:0]     table_o
);
  logic base_ok, size_ok, cnt_ok, span_ok, sel_ok, wr_ok;
  region_t new_ent;

  always_comb begin
    base_ok = (cfg_base_i[3:0] == 4'h0);
    size_ok = ($countones(cfg_size_i) == 1) && (cfg_size_i >= SIZE_W'(32));
    cnt_ok  = ($countones(cfg_count_i) == 1) && (cfg_count_i >= CNT_W'(32));
    span_ok = ({2'b00, cfg_start_i} + {1'b0, cfg_count_i}) <= {2'b00, IDX_NULL};
    sel_ok  = (32'(cfg_sel_i) < NUM_REGIONS);
    wr_ok   = cfg_we_i && base_ok && size_ok && cnt_ok && span_ok && sel_ok;
    new_ent.valid    = 1'b1;
    new_ent.base     = cfg_base_i;
    new_ent.start    = cfg_start_i;
    new_ent.size_log = onehot_log2(cfg_size_i);
    new_ent.cnt_log  = onehot_log2(cfg_count_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_err_o <= 1'b0;
    else         cfg_err_o <= cfg_we_i && !wr_ok;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_ent
    region_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      ent_q <= '0;
      else if (wr_ok && (32'(cfg_sel_i) == g))          ent_q <= new_ent;
    end
    assign table_o[g] = ent_q;

    assert_entry_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_q.valid |-> (ent_q.size_log >= LOG_W'(MIN_LOG)) && (ent_q.cnt_log >= LOG_W'(MIN_LOG))
                      && (ent_q.base[3:0] == 4'h0));
  end

  assert_err_after_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(cfg_we_i));
  assert_table_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_we_i) |-> $stable(table_o));
endmodule

// File: rtl/desc_addr2idx.sv
module desc_addr2idx
  import desc_xlate_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  region_t [NUM_REGIONS-1:0] tbl_i,
  input  logic                      valid_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic                      err_o
);
  logic              s1_valid;
  logic [ADDR_W-1:0] s1_addr;
  logic [NUM_REGIONS-1:0] hit;
  logic [IDX_W-1:0]  cand [NUM_REGIONS];
  logic [IDX_W-1:0]  sel_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
    end else begin
      s1_valid <= valid_i;
      s1_addr  <= addr_i;
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    logic [ADDR_W-1:0] off, dnum, mask;
    assign off  = s1_addr - tbl_i[g].base;
    assign dnum = off >> tbl_i[g].size_log;
    assign mask = (ADDR_W'(1) << tbl_i[g].size_log) - ADDR_W'(1);
    assign hit[g] = tbl_i[g].valid && (s1_addr >= tbl_i[g].base)
                    && ((dnum >> tbl_i[g].cnt_log) == '0) && ((off & mask) == '0);
    assign cand[g] = tbl_i[g].start + dnum[IDX_W-1:0];
  end

  // lowest region number wins
  always_comb begin
    sel_idx = IDX_NULL;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) if (hit[r]) sel_idx = cand[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= IDX_NULL;
      err_o   <= 1'b0;
    end else begin
      valid_o <= s1_valid;
      idx_o   <= (s1_valid && |hit) ? sel_idx : IDX_NULL;
      err_o   <= s1_valid && !(|hit);
    end
  end

  assert_push_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  assert_push_null_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> (idx_o == IDX_NULL));
  assert_push_not_null_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !err_o) |-> (idx_o != IDX_NULL));
endmodule

// File: rtl/desc_idx2addr.sv
module desc_idx2addr
  import desc_xlate_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  region_t [NUM_REGIONS-1:0] tbl_i,
  input  logic                      valid_i,
  input  logic [IDX_W-1:0]          idx_i,
  output logic                      valid_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic                      err_o
);
  logic              s1_valid;
  logic [IDX_W-1:0]  s1_idx;
  logic [NUM_REGIONS-1:0] hit;
  logic [ADDR_W-1:0] cand [NUM_REGIONS];
  logic [ADDR_W-1:0] sel_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= valid_i;
      s1_idx   <= idx_i;
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    logic [IDX_W-1:0] rel;
    assign rel    = s1_idx - tbl_i[g].start;
    assign hit[g] = tbl_i[g].valid && (s1_idx >= tbl_i[g].start)
                    && ((rel >> tbl_i[g].cnt_log) == '0);
    assign cand[g] = tbl_i[g].base + (ADDR_W'(rel) << tbl_i[g].size_log);
  end

  always_comb begin
    sel_addr = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) if (hit[r]) sel_addr = cand[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= s1_valid;
      addr_o  <= (s1_valid && |hit) ? sel_addr : '0;
      err_o   <= s1_valid && !(|hit);
    end
  end

  assert_pop_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  assert_pop_zero_on_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> (addr_o == '0));
  assert_pop_aligned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !err_o) |-> (addr_o[3:0] == 4'h0));
endmodule

// File: rtl/desc_xlate.sv
module desc_xlate
  import desc_xlate_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 20,
  localparam int unsigned SEL_W = $clog2(NUM_REGIONS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic [ADDR_W-1:0]  cfg_base_i,
  input  logic [IDX_W-1:0]   cfg_start_i,
  input  logic [SIZE_W-1:0]  cfg_size_i,
  input  logic [CNT_W-1:0]   cfg_count_i,
  output logic               cfg_err_o,
  input  logic               push_valid_i,
  input  logic [ADDR_W-1:0]  push_addr_i,
  output logic               push_valid_o,
  output logic [IDX_W-1:0]   push_idx_o,
  output logic               push_err_o,
  input  logic               pop_valid_i,
  input  logic [IDX_W-1:0]   pop_idx_i,
  output logic               pop_valid_o,
  output logic [ADDR_W-1:0]  pop_addr_o,
  output logic               pop_err_o
);
  region_t [NUM_REGIONS-1:0] tbl;

  desc_region_table #(.NUM_REGIONS(NUM_REGIONS)) i_table (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_base_i, .cfg_start_i,
    .cfg_size_i, .cfg_count_i, .cfg_err_o, .table_o(tbl)
  );

  desc_addr2idx #(.NUM_REGIONS(NUM_REGIONS)) i_a2i (
    .clk_i, .rst_ni, .tbl_i(tbl), .valid_i(push_valid_i), .addr_i(push_addr_i),
    .valid_o(push_valid_o), .idx_o(push_idx_o), .err_o(push_err_o)
  );

  desc_idx2addr #(.NUM_REGIONS(NUM_REGIONS)) i_i2a (
    .clk_i, .rst_ni, .tbl_i(tbl), .valid_i(pop_valid_i), .idx_i(pop_idx_i),
    .valid_o(pop_valid_o), .addr_o(pop_addr_o), .err_o(pop_err_o)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk_i)
    !rst_ni |=> !cfg_err_o && !push_valid_o && !pop_valid_o);
endmodule

// File: tb/test_desc_xlate.sv
module test_desc_xlate;
  localparam int CLK_P = 10;
  localparam int NR    = 20;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_sel = '0;
  logic [31:0] cfg_base = '0;
  logic [14:0] cfg_start = '0;
  logic [15:0] cfg_size = '0, cfg_count = '0;
  logic        cfg_err;
  logic        push_vi = 0;
  logic [31:0] push_addr = '0;
  logic        push_vo, push_err;
  logic [14:0] push_idx;
  logic        pop_vi = 0;
  logic [14:0] pop_idx = '0;
  logic        pop_vo, pop_err;
  logic [31:0] pop_addr;

  desc_xlate #(.NUM_REGIONS(NR)) i_desc_xlate (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_base_i(cfg_base), .cfg_start_i(cfg_start), .cfg_size_i(cfg_size),
    .cfg_count_i(cfg_count), .cfg_err_o(cfg_err),
    .push_valid_i(push_vi), .push_addr_i(push_addr), .push_valid_o(push_vo),
    .push_idx_o(push_idx), .push_err_o(push_err),
    .pop_valid_i(pop_vi), .pop_idx_i(pop_idx), .pop_valid_o(pop_vo),
    .pop_addr_o(pop_addr), .pop_err_o(pop_err)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench region model
  logic        mv  [NR];
  logic [31:0] mb  [NR];
  logic [31:0] mst [NR];
  logic [31:0] ms  [NR];
  logic [31:0] mc  [NR];

  // scoreboards
  logic [14:0] q_pidx[$]; logic q_perr[$]; int q_pcyc[$]; string q_ptag[$];
  logic [31:0] q_oadr[$]; logic q_oerr[$]; int q_ocyc[$]; string q_otag[$];

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s", msg); end
  endtask

  task automatic cfg(input int sel, input logic [31:0] base, input int start,
                     input int size, input int count, input bit ok, input string tag);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 5'(sel); cfg_base = base; cfg_start = 15'(start);
    cfg_size = 16'(size); cfg_count = 16'(count);
    @(posedge clk); #1;
    cfg_we = 0;
    check(cfg_err == !ok, $sformatf("%s cfg sel %0d err actual %0b expected %0b", tag, sel, cfg_err, !ok));
    if (ok) begin mv[sel] = 1; mb[sel] = base; mst[sel] = start; ms[sel] = size; mc[sel] = count; end
  endtask

  task automatic push(input logic [31:0] addr, input string tag);
    logic [14:0] e; logic er;
    e = 15'h7FFF; er = 1;
    for (int r = 0; r < NR; r++)
      if (er && mv[r] && addr >= mb[r] && ((addr - mb[r]) % ms[r]) == 0 && ((addr - mb[r]) / ms[r]) < mc[r]) begin
        e = 15'(mst[r] + (addr - mb[r]) / ms[r]); er = 0;
      end
    @(negedge clk);
    push_vi = 1; push_addr = addr;
    q_pidx.push_back(e); q_perr.push_back(er); q_pcyc.push_back(cyc + 2); q_ptag.push_back(tag);
    @(posedge clk); #1 push_vi = 0;
  endtask

  task automatic pop(input int idx, input string tag);
    logic [31:0] e; logic er;
    e = '0; er = 1;
    for (int r = 0; r < NR; r++)
      if (er && mv[r] && idx >= mst[r] && (idx - mst[r]) < mc[r]) begin
        e = mb[r] + (idx - mst[r]) * ms[r]; er = 0;
      end
    @(negedge clk);
    pop_vi = 1; pop_idx = 15'(idx);
    q_oadr.push_back(e); q_oerr.push_back(er); q_ocyc.push_back(cyc + 2); q_otag.push_back(tag);
    @(posedge clk); #1 pop_vi = 0;
  endtask

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (push_vo) begin
      if (q_pidx.size() == 0) check(0, "R9 push unexpected result actual valid expected none");
      else begin
        string t; logic [14:0] e; logic er; int c;
        t = q_ptag.pop_front(); e = q_pidx.pop_front(); er = q_perr.pop_front(); c = q_pcyc.pop_front();
        check(push_idx == e && push_err == er,
              $sformatf("%s push idx/err actual %h/%0b expected %h/%0b", t, push_idx, push_err, e, er));
        check(cyc == c, $sformatf("R9 push latency actual cycle %0d expected %0d", cyc, c));
      end
    end
    if (pop_vo) begin
      if (q_oadr.size() == 0) check(0, "R9 pop unexpected result actual valid expected none");
      else begin
        string t; logic [31:0] e; logic er; int c;
        t = q_otag.pop_front(); e = q_oadr.pop_front(); er = q_oerr.pop_front(); c = q_ocyc.pop_front();
        check(pop_addr == e && pop_err == er,
              $sformatf("%s pop addr/err actual %h/%0b expected %h/%0b", t, pop_addr, pop_err, e, er));
        check(cyc == c, $sformatf("R9 pop latency actual cycle %0d expected %0d", cyc, c));
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) begin mv[r] = 0; mb[r] = 0; mst[r] = 0; ms[r] = 1; mc[r] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check(cfg_err == 0 && push_vo == 0 && pop_vo == 0,
          $sformatf("R10 reset outputs actual %0b%0b%0b expected 000", cfg_err, push_vo, pop_vo));
    push(32'h1000, "R10"); pop(0, "R10");

    // legal regions
    cfg(0, 32'h1000, 0, 64, 32, 1, "R4");
    cfg(1, 32'h8000, 100, 128, 64, 1, "R4");
    cfg(2, 32'h1000, 500, 32, 32, 1, "R8");
    cfg(3, 32'h20000, 0, 256, 32, 1, "R8");
    cfg(19, 32'h100000, 32'h7FDF, 1024, 32, 1, "R4");

    // R5/R6/R8 back-to-back pushes
    push(32'h1000, "R8");  push(32'h1040, "R5"); push(32'h1020, "R8");
    push(32'h17C0, "R5");  push(32'h1800, "R6"); push(32'h1004, "R6");
    push(32'h8000, "R5");  push(32'h9F80, "R5"); push(32'hA000, "R6");
    push(32'h7F80, "R6");  push(32'h107C00, "R5"); push(32'h20100, "R5");
    push(32'h1400, "R6");

    // R7/R8 pops
    pop(0, "R8"); pop(31, "R7"); pop(32, "R7"); pop(100, "R7"); pop(163, "R7");
    pop(164, "R7"); pop(99, "R7"); pop(501, "R7"); pop(32'h7FFE, "R7"); pop(32'h7FFF, "R7");

    // rejected writes leave table unchanged
    cfg(4, 32'h40008, 0, 32, 32, 0, "R1");
    cfg(0, 32'h1000, 0, 48, 32, 0, "R2");
    cfg(4, 32'h40000, 0, 16, 32, 0, "R2");
    cfg(4, 32'h40000, 0, 32, 48, 0, "R3");
    cfg(4, 32'h40000, 0, 32, 16, 0, "R3");
    cfg(4, 32'h40000, 32'h7FE0, 32, 32, 0, "R4");
    cfg(20, 32'h40000, 0, 32, 32, 0, "R4");
    push(32'h40000, "R1"); push(32'h40008, "R1"); push(32'h1040, "R2"); pop(600, "R3");

    // reconfigure region 0 and see the new mapping
    cfg(0, 32'h40000, 600, 32, 32, 1, "R4");
    push(32'h40020, "R5"); pop(600, "R7"); push(32'h1040, "R8");

    repeat (4) @(posedge clk);
    #1;
    check(q_pidx.size() == 0 && q_oadr.size() == 0,
          $sformatf("R9 outstanding results actual %0d expected 0", q_pidx.size() + q_oadr.size()));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule